// File: doc/BRIEF.md
# Display Host Register Interface

This block is the processor-facing register front end of an eight-digit display controller. A host drives an asynchronous bus made of an active-low chip enable, an active-low write strobe, an active-low read strobe, a region-select line, five address lines and an 8-bit data bus. The region-select line splits the bus into two storage spaces. When it is low, the bus reaches a per-digit flash attribute memory that holds one bit for each digit. When it is high, the bus reaches a single control word that packs brightness, the flash and blink enables, a self-test start and a clear command.

The block synchronises the write strobe into the core clock. It commits each write when the strobe returns high. It exports the stored settings to the display datapath. It also drives a one-cycle clear pulse for the character and flash memories and a one-cycle self-test start pulse. Reads are combinational from the live bus. The control word read reports the result bit from a self-test stub input.

Top module: `disp_host_regs`

## Requirements
- R1: While rst_ni is low, and after it is released until the first write, every control field, every flash bit, clear_o, st_start_o and rdata_o are 0.
- R2: A write is committed only if ce_ni was low while wr_ni was low. Its effect appears on the outputs after the third rising clock edge that samples wr_ni high again, and not after the second.
- R3: A write with fsel_i=0 stores data_i[0] in the flash bit of digit addr_i[2:0], where 0 is the leftmost digit and 7 is the rightmost. That bit drives digit_flash_o[addr_i[2:0]]. data_i[7:1] and addr_i[4:3] have no effect.
- R4: A write with fsel_i=1, addr_i[4]=1 and addr_i[3]=0 loads the whole control word at once, whatever addr_i[2:0] is. Bits 2..0 drive bright_o (0 is brightest, 7 is blank), bit 3 drives flash_en_o and bit 4 drives blink_en_o.
- R5: A control write with bit 7 set clears every flash bit and pulses clear_o high for exactly one cycle. Bit 7 reads back as 0. The other fields of the same word are still loaded.
- R6: A control write with bit 6 set pulses st_start_o high for exactly one cycle and stores bit 6. The bit-5 value written is discarded.
- R7: With ce_ni and rd_ni both low, rdata_o returns one of two values. For fsel_i=0 it is {7'b0, flash bit of digit addr_i[2:0]}. For the control address it is {1'b0, bit 6, st_result_i, bits 4..0}.
- R8: A write with fsel_i=1 to any address other than the control address changes nothing. A read of such an address returns 0, and rdata_o is 0 whenever no read is in progress.
- R9: A write strobe with ce_ni high changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| wr_ni | input | 1 | Write strobe, active low, asynchronous to clk_i |
| rd_ni | input | 1 | Read strobe, active low |
| fsel_i | input | 1 | Region select: 0 flash attribute memory, 1 control space |
| addr_i | input | 5 | Bus address |
| data_i | input | 8 | Write data |
| st_result_i | input | 1 | Self-test result stub, 1 means passed |
| rdata_o | output | 8 | Read data |
| bright_o | output | 3 | Brightness code |
| flash_en_o | output | 1 | Per-digit flash attribute enable |
| blink_en_o | output | 1 | Whole-display blink enable |
| digit_flash_o | output | 8 | Flash attribute for each digit, bit 0 leftmost |
| clear_o | output | 1 | One-cycle clear pulse for the character and flash memories |
| st_start_o | output | 1 | One-cycle self-test start pulse |

## Verification
The bench measures the commit latency edge by edge. A design that commits on the falling strobe, or that drops a synchroniser stage, shows its new brightness one or two edges early. It writes flash data with bit 0 low and upper bits high, and it sets the upper address bits during flash writes. A decoder that stores the wrong bit, or that folds addr_i[4:3] into the digit index, then marks the wrong digit. It also sends writes with chip enable high and writes to control-space addresses that are not decoded. It sets bit 5 of a written control word and checks that the read returns the stub result, and it checks that clear lasts exactly one cycle, wipes every flash bit and still loads the brightness in the same word. A design that latched clear, stored bit 5, or gated on the wrong address bits would show up as a mismatch against the per-clock model.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;

  typedef struct packed {
    logic       clr;
    logic       st_go;
    logic       st_res;
    logic       blink_en;
    logic       flash_en;
    logic [2:0] bright;
  } ctrl_t;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_CTRL  = 2'd2
  } tgt_e;

endpackage

// File: rtl/dh_decode.sv
module dh_decode
  import disp_host_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          fsel_i,
  input  logic [AW-1:0] addr_i,
  output tgt_e          tgt_o
);

  always_comb begin
    if (!fsel_i)                                  tgt_o = TGT_FLASH;
    else if (addr_i[AW-1] && !addr_i[AW-2])       tgt_o = TGT_CTRL;
    else                                          tgt_o = TGT_NONE;
  end

endmodule

// File: rtl/dh_wr_sync.sv
module dh_wr_sync #(
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          wr_ni,
  input  logic          fsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          commit_o,
  output logic          fsel_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   wr_q, prev_q, ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], wr_ni};
  end

  assign wr_q = sync_q[SYNC_STAGES-1];

  // bus is held by the host across the strobe; keep the last low-phase sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      ce_q   <= 1'b1;
      fsel_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      prev_q <= wr_q;
      if (!wr_q) begin
        ce_q   <= ce_ni;
        fsel_o <= fsel_i;
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  assign commit_o = wr_q && !prev_q && !ce_q;

endmodule

// File: rtl/dh_flash_mem.sv
module dh_flash_mem #(
  parameter int NUM_DIGITS = 8,
  localparam int DIG_AW    = $clog2(NUM_DIGITS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [DIG_AW-1:0]     idx_i,
  input  logic                  bit_i,
  input  logic                  clr_i,
  output logic [NUM_DIGITS-1:0] flash_o
);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_dig
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   flash_o[g] <= 1'b0;
      else if (clr_i)                                flash_o[g] <= 1'b0;
      else if (we_i && idx_i == DIG_AW'(g))          flash_o[g] <= bit_i;
    end
  end

endmodule

// File: rtl/dh_ctrl_reg.sv
module dh_ctrl_reg
  import disp_host_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  ctrl_t data_i,
  output ctrl_t ctrl_o,
  output logic  clear_o,
  output logic  st_start_o
);

  logic unused_ok;
  assign unused_ok = data_i.st_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= '0;
      clear_o    <= 1'b0;
      st_start_o <= 1'b0;
    end else begin
      clear_o    <= we_i && data_i.clr;
      st_start_o <= we_i && data_i.st_go;
      if (we_i) begin
        ctrl_o        <= data_i;
        ctrl_o.clr    <= 1'b0;   // command bit, never held
        ctrl_o.st_res <= 1'b0;   // result comes from the stub on reads
      end
    end
  end

  // R5
  clear_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o);

  // R6
  st_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_start_o |=> !st_start_o);

endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
  import disp_host_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int AW          = 5,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ce_ni,
  input  logic                  wr_ni,
  input  logic                  rd_ni,
  input  logic                  fsel_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         data_i,
  input  logic                  st_result_i,
  output logic [DW-1:0]         rdata_o,
  output logic [2:0]            bright_o,
  output logic                  flash_en_o,
  output logic                  blink_en_o,
  output logic [NUM_DIGITS-1:0] digit_flash_o,
  output logic                  clear_o,
  output logic                  st_start_o
);

  localparam int DIG_AW = $clog2(NUM_DIGITS);

  logic          commit, wfsel;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;
  tgt_e          wtgt, rtgt;
  logic          flash_we, ctrl_we;
  ctrl_t         ctrl_q;

  dh_wr_sync #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .ce_ni, .wr_ni, .fsel_i, .addr_i, .data_i,
    .commit_o(commit), .fsel_o(wfsel), .addr_o(waddr), .data_o(wdata)
  );

  dh_decode #(.AW(AW)) u_wdec (.fsel_i(wfsel), .addr_i(waddr), .tgt_o(wtgt));
  dh_decode #(.AW(AW)) u_rdec (.fsel_i(fsel_i), .addr_i(addr_i), .tgt_o(rtgt));

  assign flash_we = commit && wtgt == TGT_FLASH;
  assign ctrl_we  = commit && wtgt == TGT_CTRL;

  dh_ctrl_reg u_ctrl (
    .clk_i, .rst_ni, .we_i(ctrl_we), .data_i(ctrl_t'(wdata)),
    .ctrl_o(ctrl_q), .clear_o(clear_o), .st_start_o(st_start_o)
  );

  dh_flash_mem #(.NUM_DIGITS(NUM_DIGITS)) u_flash (
    .clk_i, .rst_ni, .we_i(flash_we), .idx_i(waddr[DIG_AW-1:0]),
    .bit_i(wdata[0]), .clr_i(ctrl_we && wdata[DW-1]), .flash_o(digit_flash_o)
  );

  assign bright_o   = ctrl_q.bright;
  assign flash_en_o = ctrl_q.flash_en;
  assign blink_en_o = ctrl_q.blink_en;

  always_comb begin
    rdata_o = '0;
    if (!ce_ni && !rd_ni) begin
      unique case (rtgt)
        TGT_FLASH: rdata_o[0] = digit_flash_o[addr_i[DIG_AW-1:0]];
        TGT_CTRL: begin
          rdata_o        = DW'(ctrl_q);
          rdata_o[DW-1]  = 1'b0;
          rdata_o[5]     = st_result_i;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  // R5
  clear_wipes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> digit_flash_o == '0);

  // R4
  ctrl_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q != $past(ctrl_q)) |-> $past(ctrl_we));

  // R9
  flash_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (digit_flash_o != $past(digit_flash_o)) |-> $past(commit));

endmodule

// File: tb/sim_disp_host_regs.sv
module sim_disp_host_regs;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_ni = 1'b1, wr_ni = 1'b1, rd_ni = 1'b1, fsel_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] data_i = '0;
  logic       st_result_i = 1'b0;
  logic [7:0] rdata_o;
  logic [2:0] bright_o;
  logic       flash_en_o, blink_en_o, clear_o, st_start_o;
  logic [7:0] digit_flash_o;

  int n_chk = 0, n_fail = 0;
  int clear_cnt = 0, start_cnt = 0;

  always #10 clk_i = ~clk_i;

  disp_host_regs u0 (.*);

  // reference model
  logic [7:0] m_ctrl = '0, m_flash = '0;
  logic       m_clear = 1'b0, m_start = 1'b0;
  logic       p_ce = 1'b1, p_fsel = 1'b0;
  logic [4:0] p_addr = '0;
  logic [7:0] p_data = '0;
  bit         hist[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ctrl <= '0; m_flash <= '0; m_clear <= 1'b0; m_start <= 1'b0;
      hist = '{1'b1, 1'b1, 1'b1, 1'b1};
    end else begin
      hist.push_front(wr_ni);
      void'(hist.pop_back());
      m_clear <= 1'b0;
      m_start <= 1'b0;
      if (hist[2] && !hist[3] && !p_ce) begin
        if (!p_fsel) m_flash[p_addr[2:0]] <= p_data[0];
        else if (p_addr[4:3] == 2'b10) begin
          m_ctrl  <= {1'b0, p_data[6], 1'b0, p_data[4:0]};
          m_clear <= p_data[7];
          m_start <= p_data[6];
          if (p_data[7]) m_flash <= '0;
        end
      end
    end
  end

  function automatic logic [7:0] m_rd();
    if (ce_ni || rd_ni) return 8'h00;
    if (!fsel_i) return {7'b0, m_flash[addr_i[2:0]]};
    if (addr_i[4:3] == 2'b10) return {1'b0, m_ctrl[6], st_result_i, m_ctrl[4:0]};
    return 8'h00;
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    #5;
    if (rst_ni) begin
      check({5'b0, bright_o}, {5'b0, m_ctrl[2:0]}, "R4 bright");
      check({7'b0, flash_en_o}, {7'b0, m_ctrl[3]}, "R4 flash_en");
      check({7'b0, blink_en_o}, {7'b0, m_ctrl[4]}, "R4 blink_en");
      check(digit_flash_o, m_flash, "R3 digit_flash");
      check({7'b0, clear_o}, {7'b0, m_clear}, "R5 clear");
      check({7'b0, st_start_o}, {7'b0, m_start}, "R6 st_start");
      check(rdata_o, m_rd(), "R7 rdata");
      if (clear_o) clear_cnt++;
      if (st_start_o) start_cnt++;
    end
  end

  task automatic bus_write(input logic ce, input logic fs, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk_i);
    p_ce = ce; p_fsel = fs; p_addr = a; p_data = d;
    ce_ni = ce; fsel_i = fs; addr_i = a; data_i = d;
    wr_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    wr_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    ce_ni = 1'b1;
  endtask

  task automatic bus_read(input logic fs, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i);
    ce_ni = 1'b0; rd_ni = 1'b0; fsel_i = fs; addr_i = a;
    #5 d = rdata_o;
    @(negedge clk_i);
    rd_ni = 1'b1; ce_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int c0;
    repeat (3) @(negedge clk_i);
    // R1 during and after reset
    check({bright_o, flash_en_o, blink_en_o, clear_o, st_start_o}, 8'h00, "R1 ctrl in reset");
    check(digit_flash_o, 8'h00, "R1 flash in reset");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    bus_read(1'b1, 5'b10000, rd);
    check(rd, 8'h00, "R1 control read after reset");

    // R2 commit timing
    @(negedge clk_i);
    p_ce = 1'b0; p_fsel = 1'b1; p_addr = 5'b10000; p_data = 8'h15;
    ce_ni = 1'b0; fsel_i = 1'b1; addr_i = 5'b10000; data_i = 8'h15;
    wr_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    wr_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #5 check({5'b0, bright_o}, 8'h00, "R2 not yet after second edge");
    @(posedge clk_i);
    #5 check({5'b0, bright_o}, 8'h05, "R2 visible after third edge");
    check({7'b0, blink_en_o}, 8'h01, "R4 blink from 0x15");
    repeat (3) @(negedge clk_i);
    ce_ni = 1'b1;

    // R3 flash writes
    bus_write(1'b0, 1'b0, 5'b00001, 8'hFE);
    check(digit_flash_o, 8'h00, "R3 upper data bits ignored");
    bus_write(1'b0, 1'b0, 5'b11111, 8'h01);
    check(digit_flash_o, 8'h80, "R3 rightmost with addr[4:3] set");
    bus_write(1'b0, 1'b0, 5'b00010, 8'h01);
    bus_write(1'b0, 1'b0, 5'b00000, 8'h03);
    check(digit_flash_o, 8'h85, "R3 leftmost and digit 2");
    bus_write(1'b0, 1'b0, 5'b01000, 8'h00);
    check(digit_flash_o, 8'h84, "R3 remove mark");
    bus_read(1'b0, 5'b00111, rd);
    check(rd, 8'h01, "R7 flash read digit 7");
    bus_read(1'b0, 5'b00001, rd);
    check(rd, 8'h00, "R7 flash read digit 1");

    // R4 / R6 control word, addr[2:0] ignored, bit5 ignored
    bus_write(1'b0, 1'b1, 5'b10101, 8'h2B);
    check({flash_en_o, blink_en_o, 3'b0, bright_o}, 8'h83, "R4 whole word loaded");
    bus_read(1'b1, 5'b10011, rd);
    check(rd, 8'h0B, "R6 bit5 write discarded, result 0");
    st_result_i = 1'b1;
    bus_read(1'b1, 5'b10000, rd);
    check(rd, 8'h2B, "R7 result bit reports stub");
    c0 = start_cnt;
    bus_write(1'b0, 1'b1, 5'b10000, 8'h40);
    check(8'(start_cnt - c0), 8'h01, "R6 start pulse one cycle");
    bus_read(1'b1, 5'b10000, rd);
    check(rd, 8'h60, "R6 start bit stored");

    // R8 undecoded
    bus_write(1'b0, 1'b1, 5'b00000, 8'hFF);
    bus_write(1'b0, 1'b1, 5'b11000, 8'hFF);
    bus_read(1'b1, 5'b10000, rd);
    check(rd, 8'h60, "R8 undecoded writes ignored");
    bus_read(1'b1, 5'b01000, rd);
    check(rd, 8'h00, "R8 undecoded read zero");
    check(digit_flash_o, 8'h84, "R8 flash untouched");

    // R9 chip enable high
    bus_write(1'b1, 1'b1, 5'b10000, 8'h07);
    check({5'b0, bright_o}, 8'h00, "R9 ce high ignored");
    bus_write(1'b1, 1'b0, 5'b00001, 8'h01);
    check(digit_flash_o, 8'h84, "R9 ce high flash ignored");

    // R5 clear
    c0 = clear_cnt;
    bus_write(1'b0, 1'b1, 5'b10000, 8'h87);
    check(8'(clear_cnt - c0), 8'h01, "R5 clear pulse one cycle");
    check(digit_flash_o, 8'h00, "R5 flash wiped");
    check({5'b0, bright_o}, 8'h07, "R5 other fields loaded");
    bus_read(1'b1, 5'b10000, rd);
    check(rd, 8'h27, "R5 clear bit reads 0");

    // R8 no strobe
    @(negedge clk_i);
    ce_ni = 1'b0; fsel_i = 1'b1; addr_i = 5'b10000;
    #5 check(rdata_o, 8'h00, "R8 no read strobe");
    ce_ni = 1'b1;

    repeat (4) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule